// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Timer

This block sets the chopping rhythm of the internal current regulator in a full-bridge motor driver. It runs on the oscillator clock. While the bridge drives the load, a pulse from the current-sense comparator ends the drive phase. The bridge then stays off for a programmed number of cycles and then drives again. Each off period can be split: a programmable fast-decay stretch comes first and slow decay fills the rest. A single decay style can also be used for the whole off period. Each time the bridge returns to drive, a blanking window opens. Comparator pulses inside that window are disregarded, so that switching transients cannot end the drive phase early.

The timing settings come from a three-wire serial port made of a shift clock, a data line and a strobe. Twenty-bit words are shifted into a holding register, most significant bit first. A rising strobe copies the holding register into the active configuration, so the timer keeps its old settings until the strobe arrives. All three port lines are brought into the oscillator domain through synchronizer chains before their edges are detected. A sleep bit in the configuration parks the bridge in the off state until it is cleared.

Top module: `offtime_chopper`

## Requirements
- R1: Serial bits are captured on each rising edge of `ser_clk_i`, and the first bit of a word lands in bit 19. The active configuration changes only on a rising edge of `ser_stb_i`: the timing stays as it was after a word is shifted in without a strobe.
- R2: `bridge_o` encodes 2'b00 off (sleep), 2'b01 drive, 2'b10 fast decay and 2'b11 slow decay. After reset the bridge is in drive, `blank_o` is low and the configuration word is all zeros.
- R3: In drive with `blank_o` low, a high `trip_i` at a clock edge ends the drive phase. The off period then lasts 8*(N+1)-1 cycles, where N is the 5-bit field in bits 6:2, and after it the bridge returns to drive.
- R4: Mixed decay is selected when bit 17 is 1 and `mode_i` is 1. The off period then opens with 8*(M+1)-1 fast-decay cycles, where M is the 4-bit field in bits 10:7, and the remaining cycles are slow decay. If the fast part is as long as the off time or longer, the whole off period is fast decay.
- R5: When bit 17 is 0, the whole off period is slow decay. When bit 17 is 1 and `mode_i` is 0, the whole off period is fast decay.
- R6: On every entry into drive, `blank_o` goes high for the first 4, 6, 12 or 24 drive cycles. The length is selected by codes 00, 01, 10 and 11 in bits 1:0.
- R7: `trip_i` has no effect while `blank_o` is high or while the bridge is in an off period. The bridge stays in drive through the blank window, and the off-period length is unchanged.
- R8: While bit 19 is 1, the bridge is held at 2'b00 with `blank_o` low, and trips are ignored. When bit 19 is cleared, the bridge returns to drive and a new blank window starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all timing counts these cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock; a rising edge captures one data bit |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_stb_i | input | 1 | Strobe; a rising edge loads the shifted word as the active configuration |
| mode_i | input | 1 | Decay-style select pin, combined with bit 17 |
| trip_i | input | 1 | Current-limit pulse from the sense comparator |
| bridge_o | output | 2 | Bridge state: 00 off, 01 drive, 10 fast decay, 11 slow decay |
| blank_o | output | 1 | High while comparator trips are being ignored after a drive turn-on |

## Verification
Each current trip is followed by measuring three runs at the ports: fast-decay cycles, slow-decay cycles and blank cycles. These are compared with lengths computed from the loaded fields. Directed words cover three settings of the decay style: slow only, fast only, and mixed with a fast part both shorter and longer than the off time. These separate an error in the split point from an error in the total off length. Extra trip pulses are placed inside the off period and inside the blank window; any reaction to them shows up as a shortened or re-entered off period. Further patterns are a word shifted without a strobe, which tells latching apart from shifting, a sleep and wake cycle, and seeded random fields with random filler in the unused bits.

// File: rtl/otp_pkg.sv
// Shared types and field layout for the fixed off-time PWM timer.
// Assumes a 20-bit configuration word; field positions are fixed here.
package otp_pkg;
    localparam int WORD_W    = 20;
    localparam int OFF_W     = 5;
    localparam int FD_W      = 4;
    localparam int BLK_W     = 2;
    localparam int CNT_W     = OFF_W + 3;
    localparam int BC_W      = 5;
    localparam int BLK_LO    = 0;
    localparam int OFF_LO    = 2;
    localparam int FD_LO     = 7;
    localparam int INT_BIT   = 17;
    localparam int SLEEP_BIT = 19;

    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_DRIVE = 2'b01,
        BR_FAST  = 2'b10,
        BR_SLOW  = 2'b11
    } bridge_e;

    typedef struct packed {
        logic             sleep;
        logic             int_mode;
        logic [FD_W-1:0]  fd_n;
        logic [OFF_W-1:0] off_n;
        logic [BLK_W-1:0] blk_code;
    } cfg_t;
endpackage

// File: rtl/otp_serial_port.sv
// Three-wire configuration port. Synchronizes shift clock, data and strobe
// into the oscillator domain, shifts on a rising shift clock (first bit ends
// in the top bit) and copies the word to the active settings on a rising
// strobe. Assumes each serial level is held for more than SYNC_N+1 cycles.
module otp_serial_port
    import otp_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_dat_i,
    input  logic ser_stb_i,
    output cfg_t cfg_o
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              clk_prev, stb_prev;
    logic              shift_en, latch_en;
    logic [WORD_W-1:0] sreg;
    cfg_t              cfg_q;

    assign raw = {ser_stb_i, ser_dat_i, ser_clk_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_sync
            logic [SYNC_N-1:0] chain;
            // Bring one serial line into the oscillator domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_N-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_N-1];
        end
    endgenerate

    // Remember the last synchronized shift clock and strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            stb_prev <= 1'b0;
        end else begin
            clk_prev <= synced[0];
            stb_prev <= synced[2];
        end
    end

    assign shift_en = synced[0] & ~clk_prev;
    assign latch_en = synced[2] & ~stb_prev;

    // Shift one data bit in per rising shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '0;
        else if (shift_en) sreg <= {sreg[WORD_W-2:0], synced[1]};
    end

    // Copy the used fields of the holding word on a rising strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (latch_en) begin
            cfg_q.sleep    <= sreg[SLEEP_BIT];
            cfg_q.int_mode <= sreg[INT_BIT];
            cfg_q.fd_n     <= sreg[FD_LO +: FD_W];
            cfg_q.off_n    <= sreg[OFF_LO +: OFF_W];
            cfg_q.blk_code <= sreg[BLK_LO +: BLK_W];
        end
    end

    assign cfg_o = cfg_q;

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(cfg_q));
endmodule

// File: rtl/otp_interval_decode.sv
// Turns the configuration fields into cycle counts: off and fast-decay
// lengths of the form 8(N+1)-1, and the blank length from its 2-bit code.
// Purely combinational; assumes the off field is wider than the fast field.
module otp_interval_decode
    import otp_pkg::*;
(
    input  logic [OFF_W-1:0] off_n_i,
    input  logic [FD_W-1:0]  fd_n_i,
    input  logic [BLK_W-1:0] blk_code_i,
    output logic [CNT_W-1:0] toff_o,
    output logic [CNT_W-1:0] tfd_o,
    output logic [BC_W-1:0]  tblank_o
);
    localparam int PAD_W = CNT_W - FD_W - 3;

    // 8(N+1)-1 equals N followed by three ones.
    assign toff_o = {off_n_i, 3'b111};
    assign tfd_o  = {{PAD_W{1'b0}}, fd_n_i, 3'b111};

    // Map the blank code to its cycle count.
    always_comb begin
        unique case (blk_code_i)
            2'b00:   tblank_o = BC_W'(4);
            2'b01:   tblank_o = BC_W'(6);
            2'b10:   tblank_o = BC_W'(12);
            default: tblank_o = BC_W'(24);
        endcase
    end
endmodule

// File: rtl/otp_blank_timer.sv
// Comparator blanking window. Loads its length whenever the bridge enters
// drive and counts down to zero; cleared while sleeping.
module otp_blank_timer
    import otp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_i,
    input  logic            load_i,
    input  logic [BC_W-1:0] len_i,
    output logic            blank_o
);
    localparam logic [BC_W-1:0] ONE = BC_W'(1);

    logic [BC_W-1:0] cnt_q;

    // Load on drive entry, otherwise count the window down.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_i)   cnt_q <= '0;
        else if (load_i)         cnt_q <= len_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
    end

    assign blank_o = (cnt_q != '0);

    // R6
    blank_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load_i && !sleep_i) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/otp_chop_fsm.sv
// Bridge state machine: drive until an unblanked trip, then an off period of
// toff cycles. In mixed mode the first tfd off cycles are fast decay and the
// rest slow; otherwise a single style is used. Sleep parks the bridge off.
module otp_chop_fsm
    import otp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_i,
    input  logic             blank_i,
    input  logic             sleep_i,
    input  logic             int_mode_i,
    input  logic             mode_pin_i,
    input  logic [CNT_W-1:0] toff_i,
    input  logic [CNT_W-1:0] tfd_i,
    output bridge_e          state_o,
    output logic             drv_on_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    bridge_e          state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             mixed, slow_only;

    assign mixed     = int_mode_i & mode_pin_i;
    assign slow_only = ~int_mode_i;

    // Next state, off-period count and drive-entry pulse.
    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        drv_on_o = 1'b0;
        if (sleep_i) begin
            state_n = BR_OFF;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                BR_OFF: begin
                    state_n  = BR_DRIVE;
                    drv_on_o = 1'b1;
                    cnt_n    = '0;
                end
                BR_DRIVE: begin
                    if (trip_i && !blank_i) begin
                        state_n = slow_only ? BR_SLOW : BR_FAST;
                        cnt_n   = ONE;
                    end
                end
                default: begin
                    if (cnt_q >= toff_i) begin
                        state_n  = BR_DRIVE;
                        drv_on_o = 1'b1;
                        cnt_n    = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                        if (state_q == BR_FAST && mixed && cnt_q == tfd_i)
                            state_n = BR_SLOW;
                    end
                end
            endcase
        end
    end

    // Register the bridge state and off-period count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BR_DRIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state_o = state_q;

    // R3
    trip_ends_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BR_DRIVE && trip_i && !blank_i && !sleep_i)
            |=> (state_q == BR_FAST || state_q == BR_SLOW));
    // R5
    slow_only_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BR_DRIVE && trip_i && !blank_i && !sleep_i && !int_mode_i)
            |=> (state_q == BR_SLOW));
    // R7
    blank_holds_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BR_DRIVE && blank_i && !sleep_i) |=> (state_q == BR_DRIVE));
    // R4
    no_slow_to_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BR_SLOW) |=> (state_q != BR_FAST));
    // R8
    sleep_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (state_q == BR_OFF));
endmodule

// File: rtl/offtime_chopper.sv
// Fixed off-time PWM current timer top level: serial configuration port,
// interval decode, bridge state machine and blanking timer.
// Assumes trip_i and mode_i are already in the oscillator domain.
module offtime_chopper
    import otp_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk_i,
    input  logic       ser_dat_i,
    input  logic       ser_stb_i,
    input  logic       mode_i,
    input  logic       trip_i,
    output logic [1:0] bridge_o,
    output logic       blank_o
);
    cfg_t             cfg;
    logic [CNT_W-1:0] toff, tfd;
    logic [BC_W-1:0]  tblank;
    bridge_e          state;
    logic             drv_on;
    logic             blank;

    otp_serial_port #(.SYNC_N(SYNC_N)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk_i),
        .ser_dat_i (ser_dat_i),
        .ser_stb_i (ser_stb_i),
        .cfg_o     (cfg)
    );

    otp_interval_decode u_decode (
        .off_n_i    (cfg.off_n),
        .fd_n_i     (cfg.fd_n),
        .blk_code_i (cfg.blk_code),
        .toff_o     (toff),
        .tfd_o      (tfd),
        .tblank_o   (tblank)
    );

    otp_chop_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_i     (trip_i),
        .blank_i    (blank),
        .sleep_i    (cfg.sleep),
        .int_mode_i (cfg.int_mode),
        .mode_pin_i (mode_i),
        .toff_i     (toff),
        .tfd_i      (tfd),
        .state_o    (state),
        .drv_on_o   (drv_on)
    );

    otp_blank_timer u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (cfg.sleep),
        .load_i  (drv_on),
        .len_i   (tblank),
        .blank_o (blank)
    );

    assign bridge_o = state;
    assign blank_o  = blank;

    // R6
    drive_entry_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != BR_DRIVE && !cfg.sleep) |=> (state != BR_DRIVE || blank));
    // R8
    sleep_no_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BR_OFF) |-> !blank);
endmodule

// File: tb/test_offtime_chopper.sv
module test_offtime_chopper;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ser_clk, ser_dat, ser_stb, mode, trip;
    logic [1:0] bridge;
    logic       blank;
    int         total = 0;
    int         bad = 0;
    int unsigned rs;

    // Bench copy of the active settings.
    int cur_blk = 0, cur_off = 0, cur_fd = 0, cur_int = 0;

    always #5 clk = ~clk;

    offtime_chopper i_offtime_chopper (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .ser_stb_i (ser_stb),
        .mode_i    (mode),
        .trip_i    (trip),
        .bridge_o  (bridge),
        .blank_o   (blank)
    );

    function automatic int span(input int n);
        return 8 * (n + 1) - 1;
    endfunction

    function automatic int blank_len(input int code);
        case (code)
            0: return 4;
            1: return 6;
            2: return 12;
            default: return 24;
        endcase
    endfunction

    function automatic int fast_len(input int off, input int fd, input int im, input int md);
        if (im == 0) return 0;
        if (md == 0) return span(off);
        return (span(fd) < span(off)) ? span(fd) : span(off);
    endfunction

    function automatic logic [19:0] mk_word(input int blk, input int off, input int fd,
                                            input int im, input int slp, input logic [19:0] junk);
        logic [19:0] w;
        w = junk & 20'h5F800;
        w[1:0]  = blk[1:0];
        w[6:2]  = off[4:0];
        w[10:7] = fd[3:0];
        w[17]   = im[0];
        w[19]   = slp[0];
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) ser_stb = 1'b1;
        repeat (4) @(negedge clk);
        ser_stb = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic shift_word(input logic [19:0] w);
        for (int i = 19; i >= 0; i--) begin
            @(negedge clk) ser_dat = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic load(input int blk, input int off, input int fd, input int im, input int slp);
        shift_word(mk_word(blk, off, fd, im, slp, 20'($urandom)));
        strobe();
        cur_blk = blk; cur_off = off; cur_fd = fd; cur_int = im;
    endtask

    // One trip: count fast, slow and blank cycles, poke extra trips that must be ignored.
    task automatic run_chop(input int ef, input int es, input int eb, input string tag);
        int nf = 0, ns = 0, nb = 0, guard = 0;
        bit held = 1'b1;
        while (blank === 1'b1 && guard < 100) begin
            @(negedge clk); guard++;
        end
        check(bridge == 2'b01, {tag, " R3 drive before trip"}, bridge, 1);
        trip = 1'b1;
        @(negedge clk) trip = 1'b0;
        guard = 0;
        while (bridge != 2'b01 && guard < 400) begin
            if (bridge == 2'b10) nf++;
            else if (bridge == 2'b11) ns++;
            trip = (nf + ns == 2);
            @(negedge clk); guard++;
        end
        trip = 1'b0;
        check(nf == ef, {tag, " R4 fast cycles"}, nf, ef);
        check(ns == es, {tag, " R3 slow cycles"}, ns, es);
        check(nf + ns == ef + es, {tag, " R7 off length with trip in off"}, nf + ns, ef + es);
        guard = 0;
        while (blank === 1'b1 && guard < 100) begin
            if (bridge != 2'b01) held = 1'b0;
            trip = (nb == 0);
            nb++;
            @(negedge clk); guard++;
        end
        trip = 1'b0;
        check(nb == eb, {tag, " R6 blank cycles"}, nb, eb);
        check(held && bridge == 2'b01, {tag, " R7 trip in blank ignored"}, bridge, 1);
    endtask

    task automatic run_cur(input string tag);
        int f;
        f = fast_len(cur_off, cur_fd, cur_int, mode);
        run_chop(f, span(cur_off) - f, blank_len(cur_blk), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_stb = 1'b0;
        mode = 1'b0; trip = 1'b0;
        rs = $urandom(32'd4711);
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(bridge == 2'b01, "R2 reset bridge", bridge, 1);
        check(blank == 1'b0, "R2 reset blank", blank, 0);
        // R3 defaults: off 7, slow only, blank 4
        run_cur("default");
        // R4 mixed, fast shorter than off
        mode = 1'b1;
        load(3, 31, 0, 1, 0);
        run_cur("mixed short fast");
        // R4 mixed, fast longer than off
        load(1, 0, 15, 1, 0);
        run_cur("mixed long fast");
        // R5 fast only
        mode = 1'b0;
        load(2, 5, 2, 1, 0);
        run_cur("fast only");
        // R5 slow only with mode pin high
        mode = 1'b1;
        load(0, 9, 3, 0, 0);
        run_cur("slow only");
        // R1 shift without strobe keeps old timing, then strobe applies
        mode = 1'b1;
        shift_word(mk_word(1, 20, 1, 1, 0, 20'h0));
        run_cur("R1 no strobe");
        strobe();
        cur_blk = 1; cur_off = 20; cur_fd = 1; cur_int = 1;
        run_cur("R1 after strobe");
        // R8 sleep and wake
        load(3, 4, 0, 1, 1);
        check(bridge == 2'b00, "R8 sleep bridge", bridge, 0);
        check(blank == 1'b0, "R8 sleep blank", blank, 0);
        @(negedge clk) trip = 1'b1;
        @(negedge clk) trip = 1'b0;
        @(negedge clk);
        check(bridge == 2'b00, "R8 trip in sleep", bridge, 0);
        load(3, 4, 0, 1, 0);
        check(bridge == 2'b01, "R8 wake bridge", bridge, 1);
        check(blank == 1'b1, "R8 wake blank", blank, 1);
        run_cur("after wake");
        // Seeded random fields
        for (int k = 0; k < 12; k++) begin
            mode = 1'($urandom);
            load(int'($urandom % 4), int'($urandom % 32), int'($urandom % 16),
                 int'($urandom % 2), 0);
            run_cur("random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule